// File: doc/BRIEF.md
# I2C Master SCL Rate Divider

This block produces the half-period timing ticks that an I2C master sequencer uses to toggle and sample SCL. It is a down-counter loaded from a divider value. It counts only on cycles where a two-phase enable is high. That enable is high twice per instruction cycle, so the counter runs at twice the instruction rate. When the count has reached zero and an enable arrives, the block emits a one-clock rollover tick. Each half period therefore lasts (divider + 1) enabled cycles, and a full SCL period spans two rollovers.

A start pulse loads the counter and sets it running. The sequencer raises this pulse when it writes the transmit buffer. A build parameter selects what happens at a rollover. In master mode the counter reloads itself and keeps going. In one-shot mode it stops and waits for an explicit reload request. An operation-done flag halts the counter, so no further ticks are produced and SCL stays at its last level.

Top module: `scl_rate_divider`

## Requirements
- R1: Only the low 7 bits of `div_value` set the half period. Bit 7 has no effect, so 0x8A times exactly like 0x0A.
- R2: A `start` pulse loads the counter from the divider and raises `running` in the next cycle. The first tick then comes on the (divider + 1)-th cycle with `phase_en` high.
- R3: The count falls by one on each cycle with `phase_en` high and holds on every other cycle. With `phase_en` high every second clock, a half period is 2 x (divider + 1) clocks.
- R4: `tick` is high for one clock only. It is asserted only in a cycle where the count is zero, `phase_en` is high, the block is running, and neither `start` nor `op_done` is present.
- R5: With AUTO_RELOAD=1, the counter reloads from the divider at each rollover and keeps running. Ticks repeat every 2 x (divider + 1) clocks, including for divider values 0x00, 0x0A, 0x19 and 0x7F.
- R6: With AUTO_RELOAD=0, `running` falls after a rollover and no further tick appears. A later `reload_req` re-arms the counter, even while it is idle.
- R7: A `reload_req` in the same cycle as a rollover still lets that tick out. It reloads the counter, so the next half period follows with no gap, in either mode.
- R8: A `reload_req` in the middle of a count restarts the half period from the current divider value.
- R9: `op_done` suppresses any tick in its own cycle and clears `running`. No ticks follow until a new start or reload.
- R10: A synchronous reset clears the count and `running`. No ticks appear after reset until a start or reload arrives.
- R11: Priority order is reset, then `start`, then `op_done`, then `reload_req`. A `start` together with `op_done` leaves the block running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| phase_en | input | 1 | Count enable, high on two phases of each instruction cycle |
| div_value | input | REG_W | Divider register; only the low DIV_W bits are used |
| start | input | 1 | Transmit-buffer write pulse: load and start |
| reload_req | input | 1 | Reload the counter from the divider and run |
| op_done | input | 1 | Operation complete: halt and freeze |
| tick | output | 1 | One-clock rollover pulse (half SCL period) |
| running | output | 1 | Counter is active |

## Verification
The bench builds two instances with the default widths, REG_W=8 and DIV_W=7, so the full divider range up to 0x7F is exercised and the ignored top bit can be set. One instance uses AUTO_RELOAD=1 (master mode) and the other uses AUTO_RELOAD=0 (one-shot), and both receive the same stimulus. This shows in one run, side by side, the free-running tick train and the single-rollover stop, including how a reload in the rollover cycle behaves in each mode.

// File: rtl/scl_div_pkg.sv
package scl_div_pkg;

    // Action chosen for the counter in a given cycle
    typedef enum logic [2:0] {
        ACT_IDLE,   // hold state
        ACT_LOAD,   // load divider, run
        ACT_HALT,   // operation complete, stop and freeze
        ACT_COUNT,  // decrement
        ACT_WRAP,   // rollover with automatic reload
        ACT_STOP    // rollover, one-shot stop
    } div_act_e;

endpackage

// File: rtl/scl_div_arbiter.sv
module scl_div_arbiter
    import scl_div_pkg::*;
#(
    parameter bit AUTO_RELOAD = 1'b1
) (
    input  logic     start_i,
    input  logic     done_i,
    input  logic     reload_i,
    input  logic     phase_i,
    input  logic     run_i,
    input  logic     zero_i,
    output div_act_e act_o,
    output logic     tick_o
);

    div_act_e roll_act;

    // Mode variant: what a rollover does to the counter
    generate
        if (AUTO_RELOAD) begin : g_auto
            assign roll_act = ACT_WRAP;
        end else begin : g_oneshot
            assign roll_act = ACT_STOP;
        end
    endgenerate

    always_comb begin
        act_o = ACT_IDLE;
        if (start_i) begin
            act_o = ACT_LOAD;
        end else if (done_i) begin
            act_o = ACT_HALT;
        end else if (reload_i) begin
            act_o = ACT_LOAD;
        end else if (run_i && phase_i) begin
            act_o = zero_i ? roll_act : ACT_COUNT;
        end
    end

    assign tick_o = run_i && phase_i && zero_i && !start_i && !done_i;

endmodule

// File: rtl/scl_div_core.sv
module scl_div_core
    import scl_div_pkg::*;
#(
    parameter int DIV_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  div_act_e         act_i,
    input  logic [DIV_W-1:0] load_i,
    output logic             run_o,
    output logic             zero_o
);

    typedef struct packed {
        logic [DIV_W-1:0] count;
        logic             run;
    } div_state_t;

    div_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        case (act_i)
            ACT_LOAD: begin
                st_d.count = load_i;
                st_d.run   = 1'b1;
            end
            ACT_WRAP: begin
                st_d.count = load_i;
                st_d.run   = 1'b1;
            end
            ACT_HALT:  st_d.run   = 1'b0;
            ACT_STOP:  st_d.run   = 1'b0;
            ACT_COUNT: st_d.count = st_q.count - DIV_W'(1);
            default:   st_d = st_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign run_o  = st_q.run;
    assign zero_o = (st_q.count == '0);

    // R2
    load_chk: assert property (@(posedge clk) disable iff (rst)
        act_i == ACT_LOAD |=> st_q.run && st_q.count == $past(load_i));

    // R3
    dec_step_chk: assert property (@(posedge clk) disable iff (rst)
        act_i == ACT_COUNT |=> st_q.count == $past(st_q.count) - DIV_W'(1));

    // R5
    wrap_reload_chk: assert property (@(posedge clk) disable iff (rst)
        act_i == ACT_WRAP |=> st_q.run && st_q.count == $past(load_i));

    // R9
    halt_chk: assert property (@(posedge clk) disable iff (rst)
        act_i == ACT_HALT |=> !st_q.run);

    // R10
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> !st_q.run && st_q.count == '0);

endmodule

// File: rtl/scl_rate_divider.sv
module scl_rate_divider
    import scl_div_pkg::*;
#(
    parameter int REG_W       = 8,
    parameter int DIV_W       = 7,
    parameter bit AUTO_RELOAD = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             phase_en,
    input  logic [REG_W-1:0] div_value,
    input  logic             start,
    input  logic             reload_req,
    input  logic             op_done,
    output logic             tick,
    output logic             running
);

    div_act_e         act;
    logic             zero;
    logic [DIV_W-1:0] div_lo;

    // Only the low DIV_W bits of the divider register matter
    assign div_lo = div_value[DIV_W-1:0];

    generate
        if (REG_W > DIV_W) begin : g_hi_bits
            logic unused_hi;
            assign unused_hi = ^div_value[REG_W-1:DIV_W];
        end
    endgenerate

    scl_div_arbiter #(
        .AUTO_RELOAD(AUTO_RELOAD)
    ) i_arbiter (
        .start_i (start),
        .done_i  (op_done),
        .reload_i(reload_req),
        .phase_i (phase_en),
        .run_i   (running),
        .zero_i  (zero),
        .act_o   (act),
        .tick_o  (tick)
    );

    scl_div_core #(
        .DIV_W(DIV_W)
    ) i_core (
        .clk   (clk),
        .rst   (rst),
        .act_i (act),
        .load_i(div_lo),
        .run_o (running),
        .zero_o(zero)
    );

    // R4
    tick_gate_chk: assert property (@(posedge clk) disable iff (rst)
        tick |-> phase_en && running && !op_done && !start);

    // R11
    start_wins_chk: assert property (@(posedge clk) disable iff (rst)
        start && op_done |=> running);

    // R9
    done_stops_chk: assert property (@(posedge clk) disable iff (rst)
        op_done && !start |=> !running && !tick);

    generate
        if (AUTO_RELOAD) begin : g_auto_chk
            // R5
            keeps_running_chk: assert property (@(posedge clk) disable iff (rst)
                tick |=> running);
        end else begin : g_oneshot_chk
            // R6
            oneshot_stop_chk: assert property (@(posedge clk) disable iff (rst)
                tick && !reload_req && !start |=> !running);
        end
    endgenerate

endmodule

// File: tb/test_scl_rate_divider.sv
module test_scl_rate_divider;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       phase_en = 1'b0;
    logic       start = 1'b0;
    logic       reload_req = 1'b0;
    logic       op_done = 1'b0;
    logic [7:0] div = 8'h00;
    logic       tick_a, run_a, tick_b, run_b;

    int cyc = 0;
    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    typedef struct {
        int    at;
        string req;
    } exp_t;

    exp_t qa[$];
    exp_t qb[$];

    scl_rate_divider #(.REG_W(8), .DIV_W(7), .AUTO_RELOAD(1'b1)) i_scl_rate_divider (
        .clk(clk), .rst(rst), .phase_en(phase_en), .div_value(div),
        .start(start), .reload_req(reload_req), .op_done(op_done),
        .tick(tick_a), .running(run_a)
    );

    scl_rate_divider #(.REG_W(8), .DIV_W(7), .AUTO_RELOAD(1'b0)) i_scl_rate_divider_oneshot (
        .clk(clk), .rst(rst), .phase_en(phase_en), .div_value(div),
        .start(start), .reload_req(reload_req), .op_done(op_done),
        .tick(tick_b), .running(run_b)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Cycle counter and the two-phase enable: high in odd cycles
    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            #1 phase_en = cyc[0];
        end
    end

    task automatic mon(input logic tk, ref exp_t q[$], input string nm);
        while (q.size() > 0 && q[0].at < cyc) begin
            checks++;
            errors++;
            $display("FAIL %s inst %s: no tick at cycle %0d, expected tick there", q[0].req, nm, q[0].at);
            void'(q.pop_front());
        end
        if (tk) begin
            checks++;
            if (q.size() > 0 && q[0].at == cyc) begin
                void'(q.pop_front());
            end else begin
                errors++;
                $display("FAIL R4 inst %s: tick at cycle %0d, expected next tick at %0d (-1 = none)",
                         nm, cyc, (q.size() > 0) ? q[0].at : -1);
            end
        end
    endtask

    // Scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            if (!finished) begin
                mon(tick_a, qa, "auto");
                mon(tick_b, qb, "oneshot");
            end
        end
    end

    task automatic next_cycle();
        @(posedge clk);
        #2;
    endtask

    task automatic go_to(input int t);
        while (cyc < t) next_cycle();
    endtask

    task automatic align_even();
        next_cycle();
        if (cyc[0]) next_cycle();
    endtask

    task automatic at_neg();
        @(negedge clk);
    endtask

    task automatic check_bit(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    task automatic exp_a(input int at, input string r);
        qa.push_back('{at, r});
    endtask

    task automatic exp_b(input int at, input string r);
        qb.push_back('{at, r});
    endtask

    task automatic pulse_done();
        op_done = 1'b1;
        next_cycle();
        op_done = 1'b0;
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

    initial begin
        int c;
        int n;
        int vals[4];
        vals = '{0, 'h0A, 'h19, 'h7F};

        // R10: reset state and silence
        at_neg();
        check_bit("R10", "auto running in reset", run_a, 1'b0);
        check_bit("R10", "oneshot running in reset", run_b, 1'b0);
        check_bit("R10", "auto tick in reset", tick_a, 1'b0);
        go_to(3);
        rst = 1'b0;
        go_to(30);
        at_neg();
        check_bit("R10", "auto running idle after reset", run_a, 1'b0);

        // R5, R6, R2, R3, R9: divider sweep
        for (int i = 0; i < 4; i++) begin
            n = vals[i];
            align_even();
            c = cyc;
            div = n[7:0];
            start = 1'b1;
            for (int k = 0; k < 4; k++) begin
                exp_a(c + 1 + 2*n + k*(2*n + 2), (k == 0) ? "R2" : (k == 1) ? "R3" : "R5");
            end
            exp_b(c + 1 + 2*n, "R6");
            next_cycle();
            start = 1'b0;
            at_neg();
            check_bit("R2", "auto running after start", run_a, 1'b1);
            check_bit("R2", "oneshot running after start", run_b, 1'b1);
            go_to(c + 2 + 2*n);
            at_neg();
            check_bit("R6", "oneshot stopped after rollover", run_b, 1'b0);
            // op_done lands on the cycle of the would-be fifth tick
            go_to(c + 1 + 2*n + 4*(2*n + 2));
            pulse_done();
            at_neg();
            check_bit("R9", "auto running after op_done", run_a, 1'b0);
            go_to(cyc + 300);
        end

        // R1: bit 7 of the divider is ignored
        align_even();
        c = cyc;
        div = 8'h8A;
        start = 1'b1;
        exp_a(c + 21, "R1");
        exp_a(c + 43, "R1");
        exp_b(c + 21, "R1");
        next_cycle();
        start = 1'b0;
        go_to(c + 44);
        pulse_done();
        go_to(cyc + 40);

        // R7: reload in the rollover cycle
        align_even();
        c = cyc;
        div = 8'h03;
        start = 1'b1;
        exp_a(c + 7, "R7");
        exp_a(c + 15, "R7");
        exp_b(c + 7, "R7");
        exp_b(c + 15, "R7");
        next_cycle();
        start = 1'b0;
        go_to(c + 7);
        reload_req = 1'b1;
        next_cycle();
        reload_req = 1'b0;
        go_to(c + 16);
        pulse_done();
        at_neg();
        check_bit("R7", "oneshot stopped after reloaded period", run_b, 1'b0);
        go_to(cyc + 40);

        // R8: reload mid-count with a new divider
        align_even();
        c = cyc;
        div = 8'h05;
        start = 1'b1;
        next_cycle();
        start = 1'b0;
        go_to(c + 4);
        div = 8'h02;
        reload_req = 1'b1;
        exp_a(c + 9, "R8");
        exp_a(c + 15, "R8");
        exp_b(c + 9, "R8");
        next_cycle();
        reload_req = 1'b0;
        go_to(c + 16);
        pulse_done();
        go_to(cyc + 40);

        // R11: start and op_done together
        align_even();
        c = cyc;
        div = 8'h01;
        start = 1'b1;
        op_done = 1'b1;
        exp_a(c + 3, "R11");
        exp_a(c + 7, "R11");
        exp_b(c + 3, "R11");
        next_cycle();
        start = 1'b0;
        op_done = 1'b0;
        at_neg();
        check_bit("R11", "auto running after start+done", run_a, 1'b1);
        go_to(c + 8);
        pulse_done();
        go_to(cyc + 40);

        // R10: reset in the middle of a count
        align_even();
        c = cyc;
        div = 8'h02;
        start = 1'b1;
        next_cycle();
        start = 1'b0;
        go_to(c + 2);
        rst = 1'b1;
        next_cycle();
        rst = 1'b0;
        at_neg();
        check_bit("R10", "auto running after reset", run_a, 1'b0);
        check_bit("R10", "oneshot running after reset", run_b, 1'b0);
        go_to(cyc + 50);

        // R6: reload re-arms an idle counter
        align_even();
        c = cyc;
        div = 8'h01;
        reload_req = 1'b1;
        exp_a(c + 3, "R6");
        exp_a(c + 7, "R6");
        exp_b(c + 3, "R6");
        next_cycle();
        reload_req = 1'b0;
        at_neg();
        check_bit("R6", "oneshot running after idle reload", run_b, 1'b1);
        go_to(c + 8);
        pulse_done();
        go_to(cyc + 40);

        at_neg();
        mon(1'b0, qa, "auto");
        mon(1'b0, qb, "oneshot");
        if (!finished) begin
            finished = 1'b1;
            summary();
            $finish;
        end
    end

endmodule